// File: doc/BRIEF.md
# AXI4 Memory Traffic Generator and Checker

This block is an AXI4 manager that exercises a memory subordinate with a fixed, built-in test program. A single start pulse launches five test phases. Each phase writes a group of bursts and then reads the same bursts back. Every returned beat is compared with a value the block can regenerate from the beat's byte address and the phase number. Any disagreement, any error response, or a misplaced RLAST sets a sticky fail flag.

The two burst lengths used by the program are picked at elaboration from a memory-technology parameter. Sequential phases step through memory with a stride equal to the bytes in one burst. The pseudo-random phase draws burst-aligned addresses from a 32-bit LFSR. The LFSR is reseeded before the read pass, so the reads visit the written locations in the same order. When the program ends, the block raises done and reports pass or fail until the next start.

Top module: `axi_tg_top`

## Requirements
- R1: A run executes five phases in order, numbered 0 to 4. Phases 0 and 1 write one burst and then read one burst. Phases 2, 3 and 4 write BLOCK_N bursts and then read BLOCK_N bursts. No read of a phase is issued before all of that phase's writes have completed.
- R2: Phases 0, 2 and 4 use burst length A. Phases 1 and 3 use burst length B. The AxLEN value for A is 0 for DDR4, 1 for DDR5 and 3 for LPDDR5. The AxLEN value for B is 0 for DDR4, 0 for DDR5 and 3 for LPDDR5.
- R3: In phases 0 to 3, the first burst of each pass is at address 0. Each later burst is at the previous address plus (DATA_W/8)*(AxLEN+1).
- R4: In phase 4, the first burst of each pass is at address 0. Next, the LFSR state starts at 32'h12345678 and is stepped once before each further burst. One step shifts the state left by one bit and shifts in the XOR of bits 31, 21, 1 and 0 as the new bit 0. The burst address is the low ADDR_W bits of the state, with the low log2 of the burst byte count cleared. The read pass repeats the same address sequence as the write pass.
- R5: AWBURST and ARBURST are 2'b01 (INCR). AWSIZE and ARSIZE equal log2(DATA_W/8). Every WSTRB bit is 1. WLAST is 1 on beat AxLEN and on no other beat.
- R6: Write beat k of a burst at address A carries byte address b = A + k*DATA_W/8. Its 32-bit lane i (lane 0 in the least significant bits) equals (b + i) XOR (phase << 29), with b zero-extended to 32 bits.
- R7: At most one request is in flight at any time. The block issues no AW or AR request while a write response or read burst is outstanding. A valid that is not yet accepted holds its payload stable.
- R8: A read beat sets fail in the cycle after it is accepted if its data differs from the R6 value for its address, or if RLAST disagrees with the beat being beat AxLEN. fail then stays set for the rest of the run.
- R9: A BRESP or RRESP other than 2'b00 (OKAY) sets fail in the cycle after the handshake.
- R10: After the last read of phase 4, done rises and pass equals the inverse of fail. Both hold until the next start. A start while idle or done clears done and fail in the next cycle.
- R11: A start pulse while a run is in progress is ignored. The run continues its address and data sequence unchanged.
- R12: During and just after reset, all request valids, done, pass and fail are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches a test run when idle or done |
| awaddr | output | ADDR_W | Write burst address |
| awlen | output | 8 | Write burst length minus one |
| awsize | output | 3 | Write beat size code |
| awburst | output | 2 | Write burst type |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| wdata | output | DATA_W | Write data |
| wstrb | output | DATA_W/8 | Write byte strobes |
| wlast | output | 1 | Final write beat |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| bresp | input | 2 | Write response code |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| araddr | output | ADDR_W | Read burst address |
| arlen | output | 8 | Read burst length minus one |
| arsize | output | 3 | Read beat size code |
| arburst | output | 2 | Read burst type |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| rdata | input | DATA_W | Read data |
| rresp | input | 2 | Read response code |
| rlast | input | 1 | Final read beat |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished without failure |
| fail | output | 1 | Sticky failure indication |

## Verification
Request payloads and write data are combinational from registered state. They are checked at the falling edge on which the bench sees the matching valid, and again one cycle later when the bench withholds ready to test that the payload holds. The fail flag is registered, so the bench checks it at the first falling edge after the faulty beat or response handshake. The falling edge that follows the start-sampling rising edge must show done and fail already cleared. Done and pass are checked once done is observed, and again ten cycles later to confirm they hold.

// File: rtl/axi_tg_pkg.sv
package axi_tg_pkg;

    typedef enum logic [1:0] {
        TECH_DDR4,
        TECH_DDR5,
        TECH_LPDDR5
    } mem_tech_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WDAT,
        ST_BRSP,
        ST_RDAT,
        ST_DONE
    } tg_state_e;

    typedef struct packed {
        logic [7:0] len;
        logic       random;
        logic       single;
    } phase_cfg_t;

    localparam int unsigned NUM_PHASES = 5;
    localparam logic [31:0] LFSR_SEED  = 32'h1234_5678;
    localparam logic [1:0]  BURST_INCR = 2'b01;
    localparam logic [1:0]  RESP_OKAY  = 2'b00;

    function automatic logic [7:0] len_a(mem_tech_e t);
        case (t)
            TECH_DDR5:   return 8'd1;
            TECH_LPDDR5: return 8'd3;
            default:     return 8'd0;
        endcase
    endfunction

    function automatic logic [7:0] len_b(mem_tech_e t);
        return (t == TECH_LPDDR5) ? 8'd3 : 8'd0;
    endfunction

    // x^32 + x^22 + x^2 + x + 1, shifting left
    function automatic logic [31:0] lfsr_step(logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic phase_cfg_t phase_cfg(logic [2:0] p, mem_tech_e t);
        phase_cfg_t c;
        c.len    = (p == 3'd1 || p == 3'd3) ? len_b(t) : len_a(t);
        c.random = (p == 3'd4);
        c.single = (p < 3'd2);
        return c;
    endfunction

endpackage

// File: rtl/tg_pattern.sv
module tg_pattern #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic [ADDR_W-1:0] beat_addr,
    input  logic [2:0]        phase,
    output logic [DATA_W-1:0] data
);
    localparam int LANES = DATA_W / 32;

    logic [31:0] base;
    assign base = 32'(beat_addr);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign data[32*i +: 32] = (base + 32'(i)) ^ {phase, 29'd0};
    end
endmodule

// File: rtl/tg_addr_gen.sv
module tg_addr_gen #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              step,
    input  logic              rand_mode,
    input  logic [ADDR_W-1:0] stride,
    output logic [ADDR_W-1:0] addr
);
    import axi_tg_pkg::*;

    logic [31:0]       lfsr_q;
    logic [31:0]       lfsr_n;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] rand_addr;

    assign lfsr_n    = lfsr_step(lfsr_q);
    assign rand_addr = ADDR_W'(lfsr_n) & ~(stride - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || init) begin
            lfsr_q <= LFSR_SEED;
            addr_q <= '0;
        end else if (step) begin
            lfsr_q <= lfsr_n;
            addr_q <= rand_mode ? rand_addr : addr_q + stride;
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/tg_rchk.sv
module tg_rchk #(
    parameter int DATA_W = 64
) (
    input  logic              beat,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] expected,
    input  logic [1:0]        rresp,
    input  logic              rlast,
    input  logic              exp_last,
    output logic              err
);
    import axi_tg_pkg::*;

    always_comb begin
        err = 1'b0;
        if (beat) begin
            err = (rdata != expected) || (rresp != RESP_OKAY) || (rlast != exp_last);
        end
    end
endmodule

// File: rtl/axi_tg_top.sv
module axi_tg_top #(
    parameter int                    ADDR_W  = 32,
    parameter int                    DATA_W  = 64,
    parameter axi_tg_pkg::mem_tech_e TECH    = axi_tg_pkg::TECH_DDR5,
    parameter int                    BLOCK_N = 512
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    output logic [ADDR_W-1:0]   awaddr,
    output logic [7:0]          awlen,
    output logic [2:0]          awsize,
    output logic [1:0]          awburst,
    output logic                awvalid,
    input  logic                awready,
    output logic [DATA_W-1:0]   wdata,
    output logic [DATA_W/8-1:0] wstrb,
    output logic                wlast,
    output logic                wvalid,
    input  logic                wready,
    input  logic [1:0]          bresp,
    input  logic                bvalid,
    output logic                bready,
    output logic [ADDR_W-1:0]   araddr,
    output logic [7:0]          arlen,
    output logic [2:0]          arsize,
    output logic [1:0]          arburst,
    output logic                arvalid,
    input  logic                arready,
    input  logic [DATA_W-1:0]   rdata,
    input  logic [1:0]          rresp,
    input  logic                rlast,
    input  logic                rvalid,
    output logic                rready,
    output logic                done,
    output logic                pass,
    output logic                fail
);
    import axi_tg_pkg::*;

    localparam int BYTES     = DATA_W / 8;
    localparam int SIZE_CODE = $clog2(BYTES);
    localparam int CNT_W     = $clog2(BLOCK_N + 1);

    tg_state_e   state_q;
    logic [2:0]  phase_q;
    logic        wpass_q;
    logic [CNT_W-1:0] txn_q;
    logic [7:0]  beat_q;
    logic        fail_q;

    phase_cfg_t        cfg;
    logic [CNT_W-1:0]  txn_total;
    logic [ADDR_W-1:0] stride;
    logic [ADDR_W-1:0] burst_addr;
    logic [ADDR_W-1:0] beat_addr;
    logic [DATA_W-1:0] exp_data;
    logic aw_hs, ar_hs, w_hs, b_hs, r_hs;
    logic txn_end, last_txn, launch, beat_last;
    logic rd_err, b_err;

    assign cfg        = phase_cfg(phase_q, TECH);
    assign txn_total  = cfg.single ? CNT_W'(1) : CNT_W'(BLOCK_N);
    assign stride     = ADDR_W'(BYTES * (int'(cfg.len) + 1));
    assign beat_addr  = burst_addr + ADDR_W'(BYTES * int'(beat_q));
    assign beat_last  = (beat_q == cfg.len);
    assign last_txn   = (txn_q == txn_total - 1'b1);

    assign aw_hs = awvalid && awready;
    assign ar_hs = arvalid && arready;
    assign w_hs  = wvalid && wready;
    assign b_hs  = bvalid && bready;
    assign r_hs  = rvalid && rready;

    assign launch  = (state_q == ST_IDLE || state_q == ST_DONE) && start;
    assign txn_end = b_hs || (r_hs && rlast);
    assign b_err   = b_hs && (bresp != RESP_OKAY);

    tg_addr_gen #(.ADDR_W(ADDR_W)) i_addr (
        .clk       (clk),
        .rst       (rst),
        .init      (launch || (txn_end && last_txn)),
        .step      (txn_end && !last_txn),
        .rand_mode (cfg.random),
        .stride    (stride),
        .addr      (burst_addr)
    );

    tg_pattern #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_wpat (
        .beat_addr (beat_addr),
        .phase     (phase_q),
        .data      (wdata)
    );

    tg_pattern #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rpat (
        .beat_addr (beat_addr),
        .phase     (phase_q),
        .data      (exp_data)
    );

    tg_rchk #(.DATA_W(DATA_W)) i_rchk (
        .beat     (r_hs),
        .rdata    (rdata),
        .expected (exp_data),
        .rresp    (rresp),
        .rlast    (rlast),
        .exp_last (beat_last),
        .err      (rd_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            phase_q <= '0;
            wpass_q <= 1'b1;
            txn_q   <= '0;
            beat_q  <= '0;
            fail_q  <= 1'b0;
        end else begin
            if (rd_err || b_err) fail_q <= 1'b1;
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state_q <= ST_ADDR;
                        phase_q <= '0;
                        wpass_q <= 1'b1;
                        txn_q   <= '0;
                        fail_q  <= 1'b0;
                    end
                end
                ST_ADDR: begin
                    beat_q <= '0;
                    if (aw_hs)      state_q <= ST_WDAT;
                    else if (ar_hs) state_q <= ST_RDAT;
                end
                ST_WDAT: begin
                    if (w_hs) begin
                        if (beat_last) state_q <= ST_BRSP;
                        else           beat_q  <= beat_q + 8'd1;
                    end
                end
                ST_BRSP, ST_RDAT: begin
                    if (txn_end) begin
                        if (!last_txn) begin
                            txn_q   <= txn_q + 1'b1;
                            state_q <= ST_ADDR;
                        end else if (wpass_q) begin
                            wpass_q <= 1'b0;
                            txn_q   <= '0;
                            state_q <= ST_ADDR;
                        end else if (phase_q == 3'(NUM_PHASES - 1)) begin
                            state_q <= ST_DONE;
                        end else begin
                            phase_q <= phase_q + 3'd1;
                            wpass_q <= 1'b1;
                            txn_q   <= '0;
                            state_q <= ST_ADDR;
                        end
                    end else if (r_hs) begin
                        beat_q <= beat_q + 8'd1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign awvalid = (state_q == ST_ADDR) && wpass_q;
    assign arvalid = (state_q == ST_ADDR) && !wpass_q;
    assign awaddr  = burst_addr;
    assign araddr  = burst_addr;
    assign awlen   = cfg.len;
    assign arlen   = cfg.len;
    assign awsize  = 3'(SIZE_CODE);
    assign arsize  = 3'(SIZE_CODE);
    assign awburst = BURST_INCR;
    assign arburst = BURST_INCR;
    assign wvalid  = (state_q == ST_WDAT);
    assign wlast   = beat_last;
    assign wstrb   = '1;
    assign bready  = (state_q == ST_BRSP);
    assign rready  = (state_q == ST_RDAT);
    assign done    = (state_q == ST_DONE);
    assign fail    = fail_q;
    assign pass    = done && !fail_q;
endmodule

// File: rtl/tg_checker.sv
module tg_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic [ADDR_W-1:0]   awaddr,
    input logic [7:0]          awlen,
    input logic [1:0]          awburst,
    input logic                awvalid,
    input logic                awready,
    input logic [DATA_W-1:0]   wdata,
    input logic [DATA_W/8-1:0] wstrb,
    input logic                wlast,
    input logic                wvalid,
    input logic                wready,
    input logic                arvalid,
    input logic                done,
    input logic                pass,
    input logic                fail
);
    // R7
    aw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        awvalid && !awready |=> awvalid && $stable(awaddr) && $stable(awlen));

    // R7
    w_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wvalid && !wready |=> wvalid && $stable(wdata) && $stable(wlast));

    // R7
    single_req_chk: assert property (@(posedge clk) disable iff (rst)
        awvalid |-> !arvalid);

    // R5
    incr_burst_chk: assert property (@(posedge clk) disable iff (rst)
        awvalid |-> awburst == 2'b01);

    // R5
    full_strb_chk: assert property (@(posedge clk) disable iff (rst)
        wvalid |-> &wstrb);

    // R10
    verdict_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> pass == !fail);

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> done && $stable(pass));

    // R8
    sticky_fail_chk: assert property (@(posedge clk) disable iff (rst)
        fail && !start |=> fail);
endmodule

bind axi_tg_top tg_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_tg_checker (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .awaddr  (awaddr),
    .awlen   (awlen),
    .awburst (awburst),
    .awvalid (awvalid),
    .awready (awready),
    .wdata   (wdata),
    .wstrb   (wstrb),
    .wlast   (wlast),
    .wvalid  (wvalid),
    .wready  (wready),
    .arvalid (arvalid),
    .done    (done),
    .pass    (pass),
    .fail    (fail)
);

// File: tb/test_axi_tg_top.sv
`timescale 1ns/1ps
module test_axi_tg_top;
    localparam int AW = 14;
    localparam int DW = 64;
    localparam int NB = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [AW-1:0] awaddr, araddr;
    logic [7:0]    awlen, arlen;
    logic [2:0]    awsize, arsize;
    logic [1:0]    awburst, arburst;
    logic          awvalid, arvalid, wvalid, wlast, bready, rready;
    logic          awready = 1'b0, arready = 1'b0, wready = 1'b0;
    logic [DW-1:0] wdata;
    logic [7:0]    wstrb;
    logic [1:0]    bresp = 2'b00, rresp = 2'b00;
    logic          bvalid = 1'b0, rvalid = 1'b0, rlast = 1'b0;
    logic [DW-1:0] rdata = '0;
    logic          done, pass, fail;

    always #2 clk = ~clk;

    axi_tg_top #(.ADDR_W(AW), .DATA_W(DW), .TECH(axi_tg_pkg::TECH_DDR5), .BLOCK_N(NB)) i_axi_tg_top (
        .clk(clk), .rst(rst), .start(start),
        .awaddr(awaddr), .awlen(awlen), .awsize(awsize), .awburst(awburst),
        .awvalid(awvalid), .awready(awready),
        .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .wvalid(wvalid), .wready(wready),
        .bresp(bresp), .bvalid(bvalid), .bready(bready),
        .araddr(araddr), .arlen(arlen), .arsize(arsize), .arburst(arburst),
        .arvalid(arvalid), .arready(arready),
        .rdata(rdata), .rresp(rresp), .rlast(rlast), .rvalid(rvalid), .rready(rready),
        .done(done), .pass(pass), .fail(fail)
    );

    typedef struct { bit wr; int addr; int len; int ph; } op_t;
    op_t ops[$];
    logic [DW-1:0] mem [0:(1<<AW)/8-1];

    int n_chk = 0, n_err = 0;
    int wr_cnt = 0, rd_beats = 0;
    int inj_rdata = -1, inj_bresp = -1, inj_rresp = -1;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    function automatic logic [31:0] tb_lfsr(logic [31:0] s);
        return {s[30:0], ^(s & 32'h8020_0003)};
    endfunction

    function automatic logic [63:0] exp_data(int a, int b, int ph);
        logic [31:0] ba = 32'(a + 8 * b);
        logic [31:0] tag = 32'(ph) << 29;
        return {(ba + 32'd1) ^ tag, ba ^ tag};
    endfunction

    // Expected request stream built from R1..R4 for DDR5 (A=1, B=0)
    task automatic build_ops();
        ops.delete();
        for (int p = 0; p < 5; p++) begin
            int len = (p == 1 || p == 3) ? 0 : 1;
            int n = (p < 2) ? 1 : NB;
            int stride = 8 * (len + 1);
            for (int pass_i = 0; pass_i < 2; pass_i++) begin
                logic [31:0] s = 32'h1234_5678;
                int a = 0;
                for (int k = 0; k < n; k++) begin
                    op_t o;
                    o.wr = (pass_i == 0); o.addr = a; o.len = len; o.ph = p;
                    ops.push_back(o);
                    if (p == 4) begin
                        s = tb_lfsr(s);
                        a = int'(s[AW-1:0]) & ~(stride - 1);
                    end else begin
                        a = a + stride;
                    end
                end
            end
        end
    endtask

    task automatic do_write();
        op_t o;
        logic [AW-1:0] held;
        string at;
        if (ops.size() == 0 || !ops[0].wr) begin
            chk(0, "R1 unexpected write request", awaddr, 0);
            o.wr = 1; o.addr = awaddr; o.len = awlen; o.ph = 0;
        end else begin
            o = ops.pop_front();
        end
        at = (o.ph == 4) ? "R4 awaddr" : "R3 awaddr";
        chk(awaddr == AW'(o.addr), at, awaddr, o.addr);
        chk(awlen == 8'(o.len), "R2 awlen", awlen, o.len);
        chk(awsize == 3'd3 && awburst == 2'b01, "R5 awsize/awburst", {awsize, awburst}, {3'd3, 2'b01});
        chk(!arvalid, "R7 write and read request together", arvalid, 0);
        if (wr_cnt % 3 == 1) begin
            held = awaddr;
            @(negedge clk);
            chk(awvalid && awaddr == held, "R7 awaddr hold", awaddr, held);
        end
        awready = 1'b1;
        @(negedge clk);
        awready = 1'b0;
        for (int b = 0; b <= o.len; b++) begin
            logic [63:0] e = exp_data(o.addr, b, o.ph);
            while (!wvalid) @(negedge clk);
            chk(wdata == e, "R6 wdata", wdata, e);
            chk(wstrb == 8'hFF, "R5 wstrb", wstrb, 8'hFF);
            chk(wlast == (b == o.len), "R5 wlast", wlast, b == o.len);
            if (b == 0 && wr_cnt % 2 == 0) begin
                @(negedge clk);
                chk(wvalid && wdata == e, "R7 wdata hold", wdata, e);
            end
            mem[(o.addr + 8 * b) >> 3] = wdata;
            wready = 1'b1;
            @(negedge clk);
            wready = 1'b0;
        end
        bvalid = 1'b1;
        bresp = (wr_cnt == inj_bresp) ? 2'b10 : 2'b00;
        chk(bready, "R7 bready", bready, 1);
        chk(!awvalid && !arvalid, "R7 request during write response", {awvalid, arvalid}, 0);
        @(negedge clk);
        bvalid = 1'b0;
        bresp = 2'b00;
        if (wr_cnt == inj_bresp) chk(fail, "R9 fail after error BRESP", fail, 1);
        wr_cnt++;
    endtask

    task automatic do_read();
        op_t o;
        string at;
        if (ops.size() == 0 || ops[0].wr) begin
            chk(0, "R1 unexpected read request", araddr, 0);
            o.wr = 0; o.addr = araddr; o.len = arlen; o.ph = 0;
        end else begin
            o = ops.pop_front();
        end
        at = (o.ph == 4) ? "R4 araddr" : "R3 araddr";
        chk(araddr == AW'(o.addr), at, araddr, o.addr);
        chk(arlen == 8'(o.len), "R2 arlen", arlen, o.len);
        chk(arsize == 3'd3 && arburst == 2'b01, "R5 arsize/arburst", {arsize, arburst}, {3'd3, 2'b01});
        arready = 1'b1;
        @(negedge clk);
        arready = 1'b0;
        for (int b = 0; b <= o.len; b++) begin
            bit bad_d = (rd_beats == inj_rdata);
            bit bad_r = (rd_beats == inj_rresp);
            rvalid = 1'b1;
            rdata = mem[(o.addr + 8 * b) >> 3] ^ (bad_d ? 64'd1 : 64'd0);
            rresp = bad_r ? 2'b10 : 2'b00;
            rlast = (b == o.len);
            chk(rready, "R7 rready", rready, 1);
            chk(!awvalid && !arvalid, "R7 request during read burst", {awvalid, arvalid}, 0);
            @(negedge clk);
            rvalid = 1'b0;
            rlast = 1'b0;
            rresp = 2'b00;
            if (bad_d) chk(fail, "R8 fail after data mismatch", fail, 1);
            if (bad_r) chk(fail, "R9 fail after error RRESP", fail, 1);
            rd_beats++;
        end
    endtask

    // memory subordinate
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (awvalid) do_write();
                else if (arvalid) do_read();
            end
        end
    end

    task automatic run(input int d_at, input int b_at, input int r_at, input bit exp_fail, input bit mid_start);
        logic held_pass;
        build_ops();
        wr_cnt = 0; rd_beats = 0;
        inj_rdata = d_at; inj_bresp = b_at; inj_rresp = r_at;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!done && !fail, "R10 start clears done and fail", {done, fail}, 0);
        if (mid_start) begin
            repeat (60) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(!done, "R11 start during run ignored", done, 0);
        end
        while (!done) @(negedge clk);
        chk(ops.size() == 0, "R1 all phases issued", ops.size(), 0);
        chk(fail == exp_fail, "R8/R9 fail verdict", fail, exp_fail);
        chk(pass == !exp_fail, "R10 pass verdict", pass, !exp_fail);
        held_pass = pass;
        repeat (10) @(negedge clk);
        chk(done && pass == held_pass, "R10 done and pass hold", {done, pass}, {1'b1, held_pass});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(!awvalid && !arvalid && !wvalid, "R12 valids in reset", {awvalid, arvalid, wvalid}, 0);
        chk(!done && !pass && !fail, "R12 status in reset", {done, pass, fail}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!awvalid && !arvalid && !done && !pass && !fail, "R12 state after reset",
            {awvalid, arvalid, done, pass, fail}, 0);
        run(-1, -1, -1, 0, 1);   // clean run, R11 start pulse mid-run
        run(37, -1, -1, 1, 0);   // R8 corrupted read beat
        run(-1, 5, -1, 1, 0);    // R9 error write response
        run(-1, -1, 150, 1, 0);  // R9 error read response
        run(-1, -1, -1, 0, 0);   // R10 clean after failing runs
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
    end
endmodule